// File: doc/BRIEF.md
# Scalar SIMD Move Decoder

This block turns the pre-parsed fields of a scalar integer move between a general-purpose or memory operand and a vector register into a set of control signals. It takes the fields a front end has already pulled out of an instruction:

- the opcode byte, a flag for the 0x66 operand-size prefix, and the encoding class;
- the W and L bits and the vvvv field;
- the ModRM mod, reg and r/m fields and the two register-extension bits;
- the current processor mode.

It reports the transfer direction, which vector register file is involved, the operand width, the two register indices, how the bits above the operand are treated in a vector destination, and whether the encoding is an invalid opcode.

Decoding is purely combinational from the inputs, followed by one registered output stage. The input side carries a valid strobe only. The block has no ready signal and never applies back-pressure. Each accepted cycle produces a result on the next cycle, and the consumer must take every cycle in which `out_valid` is high. Register indices, size and direction hold their last value while `out_valid` is low. Write enables are only ever high together with `out_valid`.

Top module: `smov_decoder`

## Requirements
- R1: Opcode 0x6E (`dir_store`=0) loads into the vector register named by ModRM.reg from the r/m operand and raises `vec_we`. Opcode 0x7E (`dir_store`=1) stores the vector register to the r/m operand. That raises `gpr_we` when mod=3 and `mem_st` otherwise. `rm_is_mem` is 1 exactly when mod is not 3.
- R2: `vec_xmm` is 0 (MMX file) for `enc` 0 (legacy) or 1 (REX) with `pfx66`=0. It is 1 (XMM file) when `pfx66`=1 or `enc` is 2 (VEX) or 3 (EVEX).
- R3: `size64` is 1 for REX with W=1, and for VEX or EVEX with W=1 in 64-bit mode. A legacy encoding is always 32-bit, whatever W is.
- R4: REX with W=1 while `mode64`=0 raises `ud`.
- R5: Outside 64-bit mode, VEX and EVEX treat W as 0: the operation is 32-bit and raises no `ud`.
- R6: VEX or EVEX with `vvvv` other than 4'b1111 raises `ud`. For legacy and REX, `vvvv` is ignored.
- R7: VEX with L=1 raises `ud`. L is ignored for legacy, REX and EVEX.
- R8: VEX or EVEX without `pfx66` raises `ud`, and so does any opcode other than 0x6E or 0x7E.
- R9: In 64-bit mode, `vec_idx` = {reg_ext, reg} for an XMM operand and {0, reg} for MMX, and `gpr_idx` = {rm_ext, rm}. Outside 64-bit mode both extension bits are ignored.
- R10: `upper_pol` for a load is 0 for an MMX destination (zero-extend to 64 bits), 1 for a legacy or REX XMM destination (zero to 128 bits, higher bits kept) and 2 for a VEX or EVEX destination (every bit above the operand zeroed). Every store gives 3.
- R11: When `ud` is 1, `vec_we`, `gpr_we` and `mem_st` are all 0.
- R12: `out_valid` equals `in_valid` one clock later. Reset drives `out_valid` and all write enables to 0, and they are all 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| opcode | input | 8 | Opcode byte |
| pfx66 | input | 1 | 0x66 mandatory prefix present |
| enc | input | 2 | Encoding class: 0 legacy, 1 REX, 2 VEX, 3 EVEX |
| w_bit | input | 1 | W bit of REX, VEX or EVEX |
| l_bit | input | 1 | Vector-length bit |
| vvvv | input | 4 | Extra-register field (VEX/EVEX), already inverted |
| modrm_mod | input | 2 | ModRM mod field |
| modrm_reg | input | 3 | ModRM reg field |
| modrm_rm | input | 3 | ModRM r/m field |
| reg_ext | input | 1 | Extension bit for the reg field |
| rm_ext | input | 1 | Extension bit for the r/m field |
| mode64 | input | 1 | Processor is in 64-bit mode |
| out_valid | output | 1 | Decoded result valid |
| dir_store | output | 1 | 1 = store from vector, 0 = load into vector |
| vec_xmm | output | 1 | 1 = XMM file, 0 = MMX file |
| size64 | output | 1 | 1 = 64-bit operand, 0 = 32-bit |
| vec_idx | output | 4 | Vector register index |
| gpr_idx | output | 4 | General-purpose register index (r/m) |
| rm_is_mem | output | 1 | r/m operand is memory |
| upper_pol | output | 2 | Upper-bit policy code |
| ud | output | 1 | Invalid-opcode flag |
| vec_we | output | 1 | Write enable for the vector register |
| gpr_we | output | 1 | Write enable for the general-purpose register |
| mem_st | output | 1 | Memory store request |

## Verification
The bench builds the block with its default parameters: 3-bit ModRM fields, a 4-bit vvvv field, and 0x6E and 0x7E as the two opcodes. These values bring all 16 vector and general-purpose indices within reach, as well as the one vvvv pattern that is legal. The bench sweeps every combination of encoding class and mode that makes size and validity diverge, including REX.W outside 64-bit mode and VEX or EVEX W outside 64-bit mode. It also covers back-to-back valid cycles, idle gaps and a reset taken while input is valid.

// File: rtl/smov_pkg.sv
package smov_pkg;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_REX    = 2'd1,
    ENC_VEX    = 2'd2,
    ENC_EVEX   = 2'd3
  } enc_e;

  typedef enum logic [1:0] {
    POL_MMX_ZX64   = 2'd0,
    POL_SSE_KEEPHI = 2'd1,
    POL_VEC_ZERO   = 2'd2,
    POL_GP_DEST    = 2'd3
  } pol_e;

endpackage

// File: rtl/smov_legality.sv
module smov_legality
  import smov_pkg::*;
#(
  parameter logic [7:0] OPC_LOAD  = 8'h6E,
  parameter logic [7:0] OPC_STORE = 8'h7E,
  parameter int         VVVV_W    = 4
) (
  input  logic [7:0]        opcode,
  input  logic              pfx66,
  input  enc_e              enc,
  input  logic              w_bit,
  input  logic              l_bit,
  input  logic [VVVV_W-1:0] vvvv,
  input  logic              mode64,
  output logic              is_store,
  output logic              ud
);
  logic vex_like, opc_bad, vvvv_bad, len_bad, pp_bad, rexw_bad;

  always_comb begin
    vex_like = (enc == ENC_VEX) || (enc == ENC_EVEX);
    is_store = (opcode == OPC_STORE);
    opc_bad  = (opcode != OPC_LOAD) && (opcode != OPC_STORE);
    // extra-register field must be all ones for the extended encodings
    vvvv_bad = vex_like && !(&vvvv);
    len_bad  = (enc == ENC_VEX) && l_bit;
    pp_bad   = vex_like && !pfx66;
    rexw_bad = (enc == ENC_REX) && w_bit && !mode64;
    ud       = opc_bad | vvvv_bad | len_bad | pp_bad | rexw_bad;
  end
endmodule

// File: rtl/smov_field_map.sv
module smov_field_map
  import smov_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int IDX_W  = FIELD_W + 1
) (
  input  logic               pfx66,
  input  enc_e               enc,
  input  logic               w_bit,
  input  logic               mode64,
  input  logic               is_store,
  input  logic [1:0]         modrm_mod,
  input  logic [FIELD_W-1:0] modrm_reg,
  input  logic [FIELD_W-1:0] modrm_rm,
  input  logic               reg_ext,
  input  logic               rm_ext,
  output logic               vec_xmm,
  output logic               size64,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [IDX_W-1:0]   gpr_idx,
  output logic               rm_is_mem,
  output pol_e               pol
);
  logic vex_like;

  always_comb begin
    vex_like  = (enc == ENC_VEX) || (enc == ENC_EVEX);
    vec_xmm   = pfx66 | vex_like;
    unique case (enc)
      ENC_LEGACY: size64 = 1'b0;
      ENC_REX:    size64 = w_bit;
      default:    size64 = w_bit & mode64;
    endcase
    // MMX file has eight registers: extension never reaches it
    vec_idx   = {reg_ext & mode64 & vec_xmm, modrm_reg};
    gpr_idx   = {rm_ext & mode64, modrm_rm};
    rm_is_mem = (modrm_mod != 2'b11);
    if (is_store)      pol = POL_GP_DEST;
    else if (!vec_xmm) pol = POL_MMX_ZX64;
    else if (vex_like) pol = POL_VEC_ZERO;
    else               pol = POL_SSE_KEEPHI;
  end
endmodule

// File: rtl/smov_decoder.sv
module smov_decoder
  import smov_pkg::*;
#(
  parameter logic [7:0] OPC_LOAD  = 8'h6E,
  parameter logic [7:0] OPC_STORE = 8'h7E,
  parameter int         FIELD_W   = 3,
  parameter int         VVVV_W    = 4,
  localparam int        IDX_W     = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         opcode,
  input  logic               pfx66,
  input  logic [1:0]         enc,
  input  logic               w_bit,
  input  logic               l_bit,
  input  logic [VVVV_W-1:0]  vvvv,
  input  logic [1:0]         modrm_mod,
  input  logic [FIELD_W-1:0] modrm_reg,
  input  logic [FIELD_W-1:0] modrm_rm,
  input  logic               reg_ext,
  input  logic               rm_ext,
  input  logic               mode64,
  output logic               out_valid,
  output logic               dir_store,
  output logic               vec_xmm,
  output logic               size64,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [IDX_W-1:0]   gpr_idx,
  output logic               rm_is_mem,
  output logic [1:0]         upper_pol,
  output logic               ud,
  output logic               vec_we,
  output logic               gpr_we,
  output logic               mem_st
);
  enc_e             enc_t;
  logic             d_store, d_ud, d_xmm, d_s64, d_mem;
  logic [IDX_W-1:0] d_vidx, d_gidx;
  pol_e             d_pol;
  logic             ok;

  assign enc_t = enc_e'(enc);

  smov_legality #(
    .OPC_LOAD (OPC_LOAD),
    .OPC_STORE(OPC_STORE),
    .VVVV_W   (VVVV_W)
  ) u_legal (
    .opcode  (opcode),
    .pfx66   (pfx66),
    .enc     (enc_t),
    .w_bit   (w_bit),
    .l_bit   (l_bit),
    .vvvv    (vvvv),
    .mode64  (mode64),
    .is_store(d_store),
    .ud      (d_ud)
  );

  smov_field_map #(.FIELD_W(FIELD_W)) u_map (
    .pfx66    (pfx66),
    .enc      (enc_t),
    .w_bit    (w_bit),
    .mode64   (mode64),
    .is_store (d_store),
    .modrm_mod(modrm_mod),
    .modrm_reg(modrm_reg),
    .modrm_rm (modrm_rm),
    .reg_ext  (reg_ext),
    .rm_ext   (rm_ext),
    .vec_xmm  (d_xmm),
    .size64   (d_s64),
    .vec_idx  (d_vidx),
    .gpr_idx  (d_gidx),
    .rm_is_mem(d_mem),
    .pol      (d_pol)
  );

  assign ok = in_valid && !d_ud;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dir_store <= 1'b0;
      vec_xmm   <= 1'b0;
      size64    <= 1'b0;
      vec_idx   <= '0;
      gpr_idx   <= '0;
      rm_is_mem <= 1'b0;
      upper_pol <= 2'd0;
      ud        <= 1'b0;
      vec_we    <= 1'b0;
      gpr_we    <= 1'b0;
      mem_st    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      vec_we    <= ok && !d_store;
      gpr_we    <= ok && d_store && !d_mem;
      mem_st    <= ok && d_store && d_mem;
      if (in_valid) begin
        dir_store <= d_store;
        vec_xmm   <= d_xmm;
        size64    <= d_s64;
        vec_idx   <= d_vidx;
        gpr_idx   <= d_gidx;
        rm_is_mem <= d_mem;
        upper_pol <= d_pol;
        ud        <= d_ud;
      end
    end
  end
endmodule

// File: rtl/smov_decoder_chk.sv
module smov_decoder_chk #(
  parameter int  FIELD_W = 3,
  parameter int  VVVV_W  = 4,
  localparam int IDX_W   = FIELD_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        enc,
  input logic              w_bit,
  input logic              l_bit,
  input logic [VVVV_W-1:0] vvvv,
  input logic              mode64,
  input logic              out_valid,
  input logic              dir_store,
  input logic              vec_xmm,
  input logic              size64,
  input logic [IDX_W-1:0]  vec_idx,
  input logic [1:0]        upper_pol,
  input logic              ud,
  input logic              vec_we,
  input logic              gpr_we,
  input logic              mem_st
);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r12_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(vec_we || gpr_we || mem_st));
  a_r11_ud_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ud) |-> !(vec_we || gpr_we || mem_st));
  a_r1_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_we, gpr_we, mem_st}));
  a_r1_load_writes_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ud && !dir_store) |-> vec_we);
  a_r4_rexw_legacy_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc == 2'd1 && w_bit && !mode64) |=> ud);
  a_r5_w_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc[1] && !mode64) |=> !size64);
  a_r6_vvvv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc[1] && !(&vvvv)) |=> ud);
  a_r7_vex_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc == 2'd2 && l_bit) |=> ud);
  a_r9_mmx_index: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !vec_xmm) |-> !vec_idx[IDX_W-1]);
  a_r10_store_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dir_store) |-> upper_pol == 2'd3);
endmodule

bind smov_decoder smov_decoder_chk #(.FIELD_W(FIELD_W), .VVVV_W(VVVV_W)) u_chk (.*);

// File: tb/tb_smov_decoder.sv
module tb_smov_decoder;
  typedef struct packed {
    logic [7:0] opc; logic p66; logic [1:0] enc; logic w; logic l;
    logic [3:0] vv; logic [1:0] md; logic [2:0] rg; logic [2:0] rm;
    logic rx; logic bx; logic m64; logic [3:0] rq;
    // ud, store, xmm, size64, vidx[4], gidx[4], pol[2], vwe, gwe, mst
    logic [16:0] ex;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{8'h6E,1'b0,2'd0,1'b0,1'b0,4'hF,2'd3,3'd2,3'd5,1'b0,1'b0,1'b0,4'd1,{4'b0000,4'h2,4'h5,2'd0,3'b100}}, // R1 R2 MMX load
    '{8'h7E,1'b0,2'd0,1'b0,1'b0,4'hF,2'd0,3'd3,3'd6,1'b0,1'b0,1'b0,4'd1,{4'b0100,4'h3,4'h6,2'd3,3'b001}}, // R1 MMX store mem
    '{8'h6E,1'b1,2'd0,1'b0,1'b0,4'hF,2'd3,3'd7,3'd1,1'b0,1'b0,1'b0,4'd10,{4'b0010,4'h7,4'h1,2'd1,3'b100}}, // R2 R10 SSE load
    '{8'h7E,1'b1,2'd0,1'b0,1'b0,4'hF,2'd3,3'd4,3'd0,1'b0,1'b0,1'b0,4'd1,{4'b0110,4'h4,4'h0,2'd3,3'b010}}, // R1 store to GPR
    '{8'h6E,1'b1,2'd1,1'b1,1'b0,4'hF,2'd3,3'd5,3'd2,1'b1,1'b1,1'b1,4'd3,{4'b0011,4'hD,4'hA,2'd1,3'b100}}, // R3 R9 REX.W 64
    '{8'h7E,1'b0,2'd1,1'b1,1'b0,4'hF,2'd3,3'd6,3'd3,1'b1,1'b1,1'b1,4'd9,{4'b0101,4'h6,4'hB,2'd3,3'b010}}, // R9 MMX ignores ext
    '{8'h6E,1'b1,2'd1,1'b1,1'b0,4'hF,2'd3,3'd1,3'd1,1'b0,1'b0,1'b0,4'd4,{4'b1011,4'h1,4'h1,2'd1,3'b000}}, // R4 R11 REX.W outside 64
    '{8'h6E,1'b1,2'd0,1'b1,1'b0,4'hF,2'd3,3'd2,3'd2,1'b0,1'b0,1'b1,4'd3,{4'b0010,4'h2,4'h2,2'd1,3'b100}}, // R3 legacy W ignored
    '{8'h6E,1'b1,2'd2,1'b1,1'b0,4'hF,2'd3,3'd0,3'd3,1'b0,1'b0,1'b0,4'd5,{4'b0010,4'h0,4'h3,2'd2,3'b100}}, // R5 VEX W outside 64
    '{8'h7E,1'b1,2'd2,1'b1,1'b0,4'hF,2'd0,3'd1,3'd4,1'b1,1'b0,1'b1,4'd3,{4'b0111,4'h9,4'h4,2'd3,3'b001}}, // R3 VEX W in 64
    '{8'h7E,1'b1,2'd3,1'b1,1'b0,4'hF,2'd3,3'd2,3'd5,1'b0,1'b0,1'b0,4'd5,{4'b0110,4'h2,4'h5,2'd3,3'b010}}, // R5 EVEX W outside 64
    '{8'h6E,1'b1,2'd3,1'b1,1'b0,4'hF,2'd3,3'd3,3'd6,1'b1,1'b1,1'b1,4'd10,{4'b0011,4'hB,4'hE,2'd2,3'b100}}, // R10 EVEX load 64
    '{8'h6E,1'b1,2'd2,1'b0,1'b0,4'hE,2'd3,3'd0,3'd0,1'b0,1'b0,1'b1,4'd6,{4'b1010,4'h0,4'h0,2'd2,3'b000}}, // R6 VEX vvvv
    '{8'h7E,1'b1,2'd3,1'b0,1'b0,4'h7,2'd3,3'd0,3'd0,1'b0,1'b0,1'b1,4'd6,{4'b1110,4'h0,4'h0,2'd3,3'b000}}, // R6 EVEX vvvv
    '{8'h6E,1'b1,2'd2,1'b0,1'b1,4'hF,2'd3,3'd1,3'd1,1'b0,1'b0,1'b1,4'd7,{4'b1010,4'h1,4'h1,2'd2,3'b000}}, // R7 VEX L
    '{8'h6E,1'b1,2'd3,1'b0,1'b1,4'hF,2'd3,3'd1,3'd1,1'b0,1'b0,1'b1,4'd7,{4'b0010,4'h1,4'h1,2'd2,3'b100}}, // R7 EVEX L ignored
    '{8'h7E,1'b0,2'd0,1'b0,1'b1,4'hF,2'd0,3'd2,3'd2,1'b0,1'b0,1'b0,4'd7,{4'b0100,4'h2,4'h2,2'd3,3'b001}}, // R7 legacy L ignored
    '{8'h6E,1'b0,2'd2,1'b0,1'b0,4'hF,2'd3,3'd1,3'd1,1'b0,1'b0,1'b1,4'd8,{4'b1010,4'h1,4'h1,2'd2,3'b000}}, // R8 VEX no 66
    '{8'h6F,1'b1,2'd0,1'b0,1'b0,4'hF,2'd3,3'd1,3'd1,1'b0,1'b0,1'b1,4'd8,{4'b1010,4'h1,4'h1,2'd1,3'b000}}, // R8 bad opcode
    '{8'h6E,1'b1,2'd0,1'b0,1'b0,4'hF,2'd3,3'd5,3'd6,1'b1,1'b1,1'b0,4'd9,{4'b0010,4'h5,4'h6,2'd1,3'b100}}, // R9 ext ignored
    '{8'h6E,1'b0,2'd0,1'b0,1'b0,4'h0,2'd3,3'd1,3'd2,1'b0,1'b0,1'b0,4'd6,{4'b0000,4'h1,4'h2,2'd0,3'b100}}  // R6 legacy vvvv ignored
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic pfx66 = 1'b0, w_bit = 1'b0, l_bit = 1'b0, reg_ext = 1'b0, rm_ext = 1'b0, mode64 = 1'b0;
  logic [1:0] enc = '0, modrm_mod = '0;
  logic [3:0] vvvv = 4'hF;
  logic [2:0] modrm_reg = '0, modrm_rm = '0;
  logic out_valid, dir_store, vec_xmm, size64, rm_is_mem, ud, vec_we, gpr_we, mem_st;
  logic [3:0] vec_idx, gpr_idx;
  logic [1:0] upper_pol;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smov_decoder dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode = v.opc; pfx66 = v.p66; enc = v.enc; w_bit = v.w; l_bit = v.l;
    vvvv = v.vv; modrm_mod = v.md; modrm_reg = v.rg; modrm_rm = v.rm;
    reg_ext = v.rx; rm_ext = v.bx; mode64 = v.m64; in_valid = 1'b1;
  endtask

  function automatic logic [16:0] outs();
    return {ud, dir_store, vec_xmm, size64, vec_idx, gpr_idx, upper_pol, vec_we, gpr_we, mem_st};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset valid", 32'(out_valid), 32'd0);
    chk("R12 reset writes", 32'({vec_we, gpr_we, mem_st}), 32'd0);
    rst_n = 1'b1;
    // table walk, one vector per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk($sformatf("R%0d row %0d", TBL[i-1].rq, i-1), 32'(outs()), 32'(TBL[i-1].ex));
        chk("R12 valid streaming", 32'(out_valid), 32'd1);
      end
      drive(TBL[i]);
    end
    @(negedge clk);
    chk($sformatf("R%0d row %0d", TBL[NV-1].rq, NV-1), 32'(outs()), 32'(TBL[NV-1].ex));
    in_valid = 1'b0;
    // R12 idle gap: valid drops, writes drop
    @(negedge clk);
    chk("R12 idle valid", 32'(out_valid), 32'd0);
    chk("R12 idle writes", 32'({vec_we, gpr_we, mem_st}), 32'd0);
    // R11 single ud store after idle, then legal store
    drive(TBL[13]);
    @(negedge clk);
    chk("R11 ud blocks writes", 32'({ud, vec_we, gpr_we, mem_st}), 32'b1000);
    drive(TBL[3]);
    @(negedge clk);
    chk("R1 gpr store after ud", 32'({ud, vec_we, gpr_we, mem_st}), 32'b0010);
    // R12 reset while input valid
    drive(TBL[0]);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset mid-stream", 32'({out_valid, vec_we, gpr_we, mem_st}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 recover after reset", 32'({out_valid, vec_we}), 32'b11);
    in_valid = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule